// File: doc/BRIEF.md
# PS/2 Mouse Movement Packet Builder

This block turns live mouse state into the three-byte movement report that a PS/2 pointing device sends to its host. It registers the three button levels, keeps one signed running total of motion per axis, and, when there is something to report (a button change, pending motion, or an explicit report request), freezes a packet. The packet holds a status byte, an X offset byte and a Y offset byte. Those bytes then leave one at a time over a valid/ready byte stream that feeds a PS/2 serial transmitter.

Motion is reported as a 9-bit signed value per axis. The sign sits in the status byte and the low eight bits sit in the offset byte. Totals beyond the reportable range raise an overflow flag and are clamped. Motion that arrives after a packet has been frozen is kept for the following packet. The running totals themselves saturate instead of wrapping, so a long burst of motion still reads as an overflow.

Top module: `ps2_mouse_packer`

## Requirements
- R1: A packet leaves as exactly three bytes in the order status, X offset, Y offset. One byte moves per cycle in which out_valid and out_ready are both high. While out_valid is high and out_ready is low, out_valid and out_data hold steady.
- R2: In the status byte, bit 0 is the left button, bit 1 the right button and bit 2 the middle button, with 1 meaning pressed. Bit 3 is always 1.
- R3: Status bit 4 is the X sign and bit 5 is the Y sign, with 1 meaning negative. For totals from -255 to 255, each offset byte is the low eight bits of the two's-complement value: +5 gives 0x05, -3 gives 0xFD, +255 gives 0xFF and -255 gives 0x01.
- R4: A total above +255 sets the axis overflow flag (status bit 6 for X, bit 7 for Y), clears the sign and sends 0xFF. A total below -255, including -256, sets the overflow flag, sets the sign and sends 0x01.
- R5: A packet is formed when the registered buttons differ from those last reported, when either total is nonzero, or when poll is high. out_valid rises one cycle after the clock edge that samples poll. With no such cause, no packet appears.
- R6: No new packet is formed while one is still being sent. A poll that arrives during a packet is remembered and yields one more packet after the current one.
- R7: Motion that arrives after a packet has been formed goes into the next packet. Motion that has been reported is not reported again.
- R8: Each running total saturates at ±(2^(ACC_W-1)-1) and does not wrap. With the default width, nine steps of +255 still report an X overflow, and nine steps of -255 still report a Y overflow.
- R9: After reset, out_valid is low, both totals are zero and the last reported buttons read as all released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_left | input | 1 | Left button level, 1 = pressed |
| btn_right | input | 1 | Right button level |
| btn_middle | input | 1 | Middle button level |
| poll | input | 1 | Request one report regardless of change |
| mv_valid | input | 1 | Qualifies mv_dx and mv_dy for this cycle |
| mv_dx | input | DELTA_W | Signed X motion step |
| mv_dy | input | DELTA_W | Signed Y motion step |
| out_valid | output | 1 | A packet byte is on out_data |
| out_ready | input | 1 | Downstream takes the byte this cycle |
| out_data | output | 8 | Packet byte |

## Verification
Each result has its own latency. A poll shows as out_valid one edge later. A button change passes through one input register, so its packet appears two edges later. A motion step first enters its running total and the packet follows on the next edge. After a byte is accepted, the next byte is on out_data after that same edge. Inputs are driven and outputs sampled on the falling clock edge. A packet is collected only once out_valid is seen high, and the bench then steps through the three bytes one edge apart. The "nothing happens" checks watch out_valid over several idle cycles placed after the last due edge.

// File: rtl/ps2m_pkg.sv
package ps2m_pkg;

    localparam int OFS_LIMIT = 255;

    typedef struct packed {
        logic y_ovf;
        logic x_ovf;
        logic y_neg;
        logic x_neg;
        logic always1;
        logic middle;
        logic right;
        logic left;
    } status_t;

    typedef struct packed {
        status_t    status;
        logic [7:0] x_byte;
        logic [7:0] y_byte;
    } pkt_t;

    typedef struct packed {
        logic       ovf;
        logic       neg;
        logic [7:0] ofs;
    } axis_code_t;

    typedef enum logic [1:0] {
        SND_IDLE,
        SND_STAT,
        SND_XOFS,
        SND_YOFS
    } send_state_e;

    // Map a signed motion total onto sign, overflow and offset byte.
    function automatic axis_code_t encode_axis(input logic signed [31:0] v);
        axis_code_t c;
        if (v > OFS_LIMIT) begin
            c.ovf = 1'b1;
            c.neg = 1'b0;
            c.ofs = 8'hFF;
        end else if (v < -OFS_LIMIT) begin
            c.ovf = 1'b1;
            c.neg = 1'b1;
            c.ofs = 8'h01;
        end else begin
            c.ovf = 1'b0;
            c.neg = (v < 0);
            c.ofs = v[7:0];
        end
        return c;
    endfunction

endpackage

// File: rtl/ps2m_axis_acc.sv
module ps2m_axis_acc #(
    parameter int ACC_W   = 11,
    parameter int DELTA_W = 9
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      add_en,
    input  logic                      clr,
    input  logic signed [DELTA_W-1:0] delta,
    output logic signed [ACC_W-1:0]   acc
);
    localparam int SUM_W = ACC_W + 1;
    localparam logic signed [SUM_W-1:0] LIM_HI = SUM_W'((2 ** (ACC_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] LIM_LO = -LIM_HI;

    logic signed [SUM_W-1:0] base;
    logic signed [SUM_W-1:0] step;
    logic signed [SUM_W-1:0] sum;

    always_comb begin
        base = clr ? '0 : SUM_W'(acc);
        step = add_en ? SUM_W'(delta) : '0;
        sum  = base + step;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (sum > LIM_HI) begin
            acc <= ACC_W'(LIM_HI);
        end else if (sum < LIM_LO) begin
            acc <= ACC_W'(LIM_LO);
        end else begin
            acc <= ACC_W'(sum);
        end
    end

    // R7: a total only moves on motion or when handed to a packet
    assert_total_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (!add_en && !clr) |=> $stable(acc));

endmodule

// File: rtl/ps2m_byte_sender.sv
module ps2m_byte_sender
    import ps2m_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  pkt_t       pkt,
    input  logic       out_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       busy
);
    send_state_e state;
    pkt_t        held;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SND_IDLE;
            held  <= '0;
        end else begin
            unique case (state)
                SND_IDLE: if (load) begin
                    held  <= pkt;
                    state <= SND_STAT;
                end
                SND_STAT: if (out_ready) state <= SND_XOFS;
                SND_XOFS: if (out_ready) state <= SND_YOFS;
                SND_YOFS: if (out_ready) state <= SND_IDLE;
                default:  state <= SND_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            SND_STAT: out_data = held.status;
            SND_XOFS: out_data = held.x_byte;
            SND_YOFS: out_data = held.y_byte;
            default:  out_data = 8'h00;
        endcase
    end

    assign out_valid = (state != SND_IDLE);
    assign busy      = out_valid;

    // R1: a stalled byte stays put
    assert_stall_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R1: the status byte is followed by the X byte
    assert_order_R1: assert property (@(posedge clk) disable iff (rst)
        (state == SND_STAT && out_ready) |=> (state == SND_XOFS));

    // R2: the first byte always carries the fixed one in bit 3
    assert_fixed_bit_R2: assert property (@(posedge clk) disable iff (rst)
        (state == SND_STAT) |-> out_data[3]);

    // R6: after the last byte the stream goes idle for at least a cycle
    assert_gap_after_last_R6: assert property (@(posedge clk) disable iff (rst)
        (state == SND_YOFS && out_ready) |=> !out_valid);

endmodule

// File: rtl/ps2_mouse_packer.sv
module ps2_mouse_packer
    import ps2m_pkg::*;
#(
    parameter int ACC_W   = 11,
    parameter int DELTA_W = 9
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      btn_left,
    input  logic                      btn_right,
    input  logic                      btn_middle,
    input  logic                      poll,
    input  logic                      mv_valid,
    input  logic signed [DELTA_W-1:0] mv_dx,
    input  logic signed [DELTA_W-1:0] mv_dy,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [7:0]                out_data
);
    localparam int NUM_BTN = 3;

    logic [NUM_BTN-1:0]     btn_q;
    logic [NUM_BTN-1:0]     btn_sent;
    logic                   poll_pend;
    logic                   busy;
    logic                   load;
    logic signed [ACC_W-1:0] acc_x;
    logic signed [ACC_W-1:0] acc_y;
    axis_code_t             code_x;
    axis_code_t             code_y;
    pkt_t                   pkt;

    always_ff @(posedge clk) begin
        if (rst) begin
            btn_q     <= '0;
            btn_sent  <= '0;
            poll_pend <= 1'b0;
        end else begin
            btn_q     <= {btn_middle, btn_right, btn_left};
            poll_pend <= (poll_pend | poll) & ~load;
            if (load) btn_sent <= btn_q;
        end
    end

    assign load = !busy && (poll || poll_pend || (btn_q != btn_sent)
                            || (acc_x != '0) || (acc_y != '0));

    ps2m_axis_acc #(.ACC_W(ACC_W), .DELTA_W(DELTA_W)) u_acc_x (
        .clk(clk), .rst(rst), .add_en(mv_valid), .clr(load),
        .delta(mv_dx), .acc(acc_x)
    );

    ps2m_axis_acc #(.ACC_W(ACC_W), .DELTA_W(DELTA_W)) u_acc_y (
        .clk(clk), .rst(rst), .add_en(mv_valid), .clr(load),
        .delta(mv_dy), .acc(acc_y)
    );

    always_comb begin
        code_x             = encode_axis(32'(acc_x));
        code_y             = encode_axis(32'(acc_y));
        pkt.status.left    = btn_q[0];
        pkt.status.right   = btn_q[1];
        pkt.status.middle  = btn_q[2];
        pkt.status.always1 = 1'b1;
        pkt.status.x_neg   = code_x.neg;
        pkt.status.y_neg   = code_y.neg;
        pkt.status.x_ovf   = code_x.ovf;
        pkt.status.y_ovf   = code_y.ovf;
        pkt.x_byte         = code_x.ofs;
        pkt.y_byte         = code_y.ofs;
    end

    ps2m_byte_sender u_sender (
        .clk(clk), .rst(rst), .load(load), .pkt(pkt),
        .out_ready(out_ready), .out_valid(out_valid),
        .out_data(out_data), .busy(busy)
    );

endmodule

// File: tb/ps2_mouse_packer_bench.sv
module ps2_mouse_packer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 9;

    logic clk = 1'b0;
    logic rst;
    logic btn_left, btn_right, btn_middle, poll, mv_valid, out_ready;
    logic signed [DW-1:0] mv_dx, mv_dy;
    logic out_valid;
    logic [7:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ps2_mouse_packer #(.ACC_W(11), .DELTA_W(DW)) u_ps2_mouse_packer (
        .clk(clk), .rst(rst), .btn_left(btn_left), .btn_right(btn_right),
        .btn_middle(btn_middle), .poll(poll), .mv_valid(mv_valid),
        .mv_dx(mv_dx), .mv_dy(mv_dy), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] expect_pkt(input logic [2:0] b, input int x, input int y);
        logic [7:0] s;
        logic [7:0] xb;
        logic [7:0] yb;
        s = {5'b00001, b};
        if (x > 255) begin s[6] = 1; xb = 8'hFF; end
        else if (x < -255) begin s[6] = 1; s[4] = 1; xb = 8'h01; end
        else begin s[4] = (x < 0); xb = x[7:0]; end
        if (y > 255) begin s[7] = 1; yb = 8'hFF; end
        else if (y < -255) begin s[7] = 1; s[5] = 1; yb = 8'h01; end
        else begin s[5] = (y < 0); yb = y[7:0]; end
        return {s, xb, yb};
    endfunction

    // Wait for a packet, then take its three bytes with ready held high.
    task automatic grab_and_check(input string req, input logic [23:0] exp);
        int waited = 0;
        logic [23:0] got;
        while (!out_valid && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        check({req, " packet present"}, {31'd0, out_valid}, 32'd1);
        if (!out_valid) return;
        out_ready = 1'b1;
        got[23:16] = out_data;
        @(negedge clk);
        check({req, " second byte valid"}, {31'd0, out_valid}, 32'd1);
        got[15:8] = out_data;
        @(negedge clk);
        got[7:0] = out_data;
        @(negedge clk);
        out_ready = 1'b0;
        check(req, {8'd0, got}, {8'd0, exp});
    endtask

    task automatic expect_quiet(input string req, input int cycles);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (out_valid) seen++;
        end
        check(req, seen, 0);
    endtask

    task automatic step_motion(input logic signed [DW-1:0] dx, input logic signed [DW-1:0] dy);
        mv_valid = 1'b1;
        mv_dx = dx;
        mv_dy = dy;
        @(negedge clk);
        mv_valid = 1'b0;
        mv_dx = '0;
        mv_dy = '0;
    endtask

    task automatic pulse_poll();
        poll = 1'b1;
        @(negedge clk);
        poll = 1'b0;
    endtask

    task automatic test_reset();
        check("R9 out_valid low after reset", {31'd0, out_valid}, 32'd0);
        expect_quiet("R5 R9 no packet without cause", 6);
    endtask

    task automatic test_poll();
        pulse_poll();
        check("R5 out_valid one edge after poll", {31'd0, out_valid}, 32'd1);
        check("R2 first byte is status", {24'd0, out_data}, 32'h08);
        grab_and_check("R1 R2 poll packet", expect_pkt(3'b000, 0, 0));
        expect_quiet("R5 single packet per poll", 5);
    endtask

    task automatic test_buttons();
        btn_left = 1'b1; btn_middle = 1'b1;
        grab_and_check("R2 left and middle", expect_pkt(3'b101, 0, 0));
        btn_left = 1'b0; btn_middle = 1'b0; btn_right = 1'b1;
        grab_and_check("R2 right only", expect_pkt(3'b010, 0, 0));
        btn_right = 1'b0;
        grab_and_check("R5 release reported", expect_pkt(3'b000, 0, 0));
        expect_quiet("R5 steady buttons silent", 6);
    endtask

    task automatic test_small_motion();
        step_motion(9'sd5, -9'sd3);
        grab_and_check("R3 small signed motion", expect_pkt(3'b000, 5, -3));
        expect_quiet("R7 reported motion not repeated", 6);
    endtask

    task automatic test_edge_motion();
        logic [7:0] first;
        pulse_poll();
        first = out_data;
        step_motion(9'sd255, -9'sd255);
        check("R1 stalled byte stable", {24'd0, out_data}, {24'd0, first});
        check("R1 stalled valid held", {31'd0, out_valid}, 32'd1);
        grab_and_check("R7 motion after forming excluded", expect_pkt(3'b000, 0, 0));
        grab_and_check("R3 range limits", expect_pkt(3'b000, 255, -255));
    endtask

    task automatic test_overflow();
        pulse_poll();
        step_motion(9'sd200, -9'sd256);
        step_motion(9'sd200, 9'sd0);
        grab_and_check("R6 poll packet first", expect_pkt(3'b000, 0, 0));
        grab_and_check("R4 X high and Y -256 overflow", expect_pkt(3'b000, 400, -256));
        step_motion(-9'sd256, 9'sd0);
        grab_and_check("R4 X -256 overflow", expect_pkt(3'b000, -256, 0));
    endtask

    task automatic test_saturation();
        pulse_poll();
        for (int i = 0; i < 9; i++) step_motion(9'sd255, -9'sd255);
        grab_and_check("R6 held poll packet", expect_pkt(3'b000, 0, 0));
        grab_and_check("R8 saturated totals overflow", expect_pkt(3'b000, 2295, -2295));
        expect_quiet("R8 R7 totals cleared after report", 6);
    endtask

    task automatic test_poll_during_busy();
        pulse_poll();
        @(negedge clk);
        pulse_poll();
        check("R6 stalled status byte", {24'd0, out_data}, 32'h08);
        grab_and_check("R6 first packet", expect_pkt(3'b000, 0, 0));
        grab_and_check("R6 remembered poll packet", expect_pkt(3'b000, 0, 0));
        expect_quiet("R6 only one extra packet", 6);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        btn_left = 0; btn_right = 0; btn_middle = 0; poll = 0;
        mv_valid = 0; mv_dx = '0; mv_dy = '0; out_ready = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_poll();
        test_buttons();
        test_small_motion();
        test_edge_motion();
        test_overflow();
        test_saturation();
        test_poll_during_busy();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule